// File: doc/BRIEF.md
# Wait-State Memory Slave for a Pipelined System Bus

This block is a small word-organised memory that sits as a slave on a pipelined, multiplexed system bus. The bus has separate read and write data paths and uses only the rising clock edge. A transfer has two phases. In the one-cycle address phase the master presents select, address, direction and size. In the following data phase the slave stretches the transfer by pulling its ready output low, then finishes it by driving ready high. The address phase of the next transfer overlaps the data phase of the current one. The slave accepts a new address only on an edge where the shared bus ready is high.

A parameter sets how many ready-low cycles each in-range access takes, so the same block can stand in for a fast or a slow device. Writes may be a byte, a halfword or a word. The lanes to update come from the low address bits and the size, in little-endian order. A write beyond the memory range gets a two-cycle error response and leaves storage alone. Bursts appear to this slave as a run of single transfers.

Top module: `bslv_top`

## Requirements
- R1: After reset, and whenever no transfer is in its data phase (the last edge with `ready_in` high saw `sel` or `xfer_req` low), `ready_out` is 1 and `resp_err` is 0 (OKAY). Every memory word reads as zero after reset.
- R2: Address, direction and size are captured only on a rising edge where `ready_in` is 1. Values driven while `ready_in` is 0 and withdrawn before it returns high start no transfer.
- R3: An in-range access captured at edge E keeps `ready_out` low for exactly `WAITS` cycles after E. It drives `ready_out` high in the next cycle with `resp_err` 0.
- R4: For an in-range read, `rdata` holds the stored word at byte address bits [IDXW+1:2] in the cycle where `ready_out` is high.
- R5: A write takes `wdata` from the completion cycle and updates only the enabled lanes, where lane k is `wdata[8k+7:8k]`. Size 2'b00 (byte) enables lane addr[1:0]. Size 2'b01 (halfword) enables lanes {addr[1],0} and {addr[1],1}. Size 2'b10 or 2'b11 (word) enables all four lanes.
- R6: A write to a byte address at or beyond `DEPTH*4` gives `ready_out`=0, `resp_err`=1 in the first data-phase cycle, then `ready_out`=1, `resp_err`=1 in the second. No word changes.
- R7: An address phase presented during a stalled data phase is held and is accepted at the completion edge. Its data phase starts in the next cycle with no idle cycle between the two transfers.
- R8: With `WAITS`=0, every in-range data phase completes in a single cycle. A write followed directly by a read of the same word returns the new value.
- R9: An out-of-range read goes through the normal `WAITS` ready-low cycles and completes with `rdata`=0 and `resp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Slave select from the address decoder |
| xfer_req | input | 1 | High for a real transfer, low for an idle slot |
| addr | input | ADDR_W | Byte address |
| write | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| wdata | input | 32 | Write data, valid in the data phase |
| ready_in | input | 1 | Shared bus ready; high marks the end of the current transfer |
| rdata | output | 32 | Read data, valid when `ready_out` is high |
| ready_out | output | 1 | Slave ready; low inserts a wait cycle |
| resp_err | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The main instance is built with `WAITS`=2, `DEPTH`=16 and `ADDR_W`=8. Two wait cycles make the stretched data phase long enough to present, hold and withdraw an overlapping address phase. The 64-byte range is small enough that the address 0x40 falls just beyond the top word and exercises the error and zero-read paths. A second instance with `WAITS`=0 covers single-cycle data phases and read-after-write between adjacent transfers.

// File: rtl/bslv_pkg.sv
package bslv_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } xfer_size_e;

  // Little-endian lane enables from the low address bits and the size.
  function automatic logic [LANES-1:0] lane_enables(input logic [OFF_W-1:0] off,
                                                    input logic [1:0]        sz);
    logic [LANES-1:0] m;
    case (xfer_size_e'(sz))
      SZ_BYTE: m = LANES'(1) << off;
      SZ_HALF: m = LANES'(3) << {off[OFF_W-1:1], 1'b0};
      default: m = '1;
    endcase
    return m;
  endfunction

  // Replace the enabled lanes of an old word with those of a new one.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[8*k +: 8] = en[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/bslv_phase_reg.sv
module bslv_phase_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              xfer_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic              ready_in,
  output logic              accept,
  output logic              ph_valid,
  output logic [ADDR_W-1:0] ph_addr,
  output logic              ph_write,
  output logic [1:0]        ph_size
);

  assign accept = ready_in && sel && xfer_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_valid <= 1'b0;
      ph_addr  <= '0;
      ph_write <= 1'b0;
      ph_size  <= 2'b00;
    end else if (ready_in) begin
      ph_valid <= sel && xfer_req;
      if (sel && xfer_req) begin
        ph_addr  <= addr;
        ph_write <= write;
        ph_size  <= size;
      end
    end
  end

  // R2: nothing is sampled while the bus is stalled
  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_in |=> $stable(ph_addr) && $stable(ph_write) && $stable(ph_valid));

endmodule

// File: rtl/bslv_wait_ctrl.sv
module bslv_wait_ctrl #(
  parameter int WAITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  input  logic ph_valid,
  input  logic ph_err,
  output logic ready_out,
  output logic resp_err,
  output logic complete
);

  localparam int CW = $clog2(WAITS + 2);

  logic [CW-1:0] cnt;
  logic          wait_done;
  logic          err_done;

  assign wait_done = (cnt == CW'(WAITS));
  assign err_done  = (cnt == CW'(1));

  always_comb begin
    if (!ph_valid)   ready_out = 1'b1;
    else if (ph_err) ready_out = err_done;
    else             ready_out = wait_done;
  end

  assign resp_err = ph_valid && ph_err;
  assign complete = ph_valid && ready_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (ready_in)              cnt <= '0;
    else if (ph_valid && !ready_out) cnt <= cnt + CW'(1);
  end

  // R3: the stall counter never runs past the configured wait count
  a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= ((WAITS > 1) ? WAITS : 1));

  // R6: an error response is low-ready once, then high-ready
  a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_err && !ready_out) |=> (resp_err && ready_out));

endmodule

// File: rtl/bslv_store.sv
module bslv_store #(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [$clog2(DEPTH)-1:0]    idx,
  input  logic [bslv_pkg::LANES-1:0]  lanes,
  input  logic [bslv_pkg::DATA_W-1:0] wdata,
  output logic [bslv_pkg::DATA_W-1:0] rdata
);

  localparam int DW = bslv_pkg::DATA_W;

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (we && (idx == $clog2(DEPTH)'(g)))
        words[g] <= bslv_pkg::lane_merge(words[g], wdata, lanes);
    end
  end

  assign rdata = words[idx];

endmodule

// File: rtl/bslv_top.sv
module bslv_top #(
  parameter int WAITS  = 2,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel,
  input  logic                        xfer_req,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        write,
  input  logic [1:0]                  size,
  input  logic [bslv_pkg::DATA_W-1:0] wdata,
  input  logic                        ready_in,
  output logic [bslv_pkg::DATA_W-1:0] rdata,
  output logic                        ready_out,
  output logic                        resp_err
);

  localparam int LANES = bslv_pkg::LANES;
  localparam int OFF_W = bslv_pkg::OFF_W;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int RANGE = DEPTH * LANES;

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return 32'(a) < 32'(RANGE);
  endfunction

  logic              accept;
  logic              ph_valid;
  logic [ADDR_W-1:0] ph_addr;
  logic              ph_write;
  logic [1:0]        ph_size;
  logic              ph_inside;
  logic              ph_err;
  logic              complete;
  logic              mem_we;
  logic [LANES-1:0]  lanes;
  logic [IDXW-1:0]   widx;
  logic [bslv_pkg::DATA_W-1:0] mem_rd;

  bslv_phase_reg #(.ADDR_W(ADDR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .sel(sel), .xfer_req(xfer_req), .addr(addr),
    .write(write), .size(size), .ready_in(ready_in), .accept(accept),
    .ph_valid(ph_valid), .ph_addr(ph_addr), .ph_write(ph_write), .ph_size(ph_size)
  );

  assign ph_inside = in_range(ph_addr);
  assign ph_err    = ph_write && !ph_inside;

  bslv_wait_ctrl #(.WAITS(WAITS)) u_wait (
    .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .ph_valid(ph_valid),
    .ph_err(ph_err), .ready_out(ready_out), .resp_err(resp_err), .complete(complete)
  );

  assign lanes  = bslv_pkg::lane_enables(ph_addr[OFF_W-1:0], ph_size);
  assign widx   = ph_addr[OFF_W +: IDXW];
  assign mem_we = complete && ph_write && ph_inside;

  bslv_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .idx(widx), .lanes(lanes),
    .wdata(wdata), .rdata(mem_rd)
  );

  assign rdata = (ph_valid && !ph_write && ph_inside) ? mem_rd : '0;

  // R1: an edge with bus ready and no request leaves the slave idle and OKAY
  a_r1_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_in && !(sel && xfer_req)) |=> (ready_out && !resp_err));

  // R6: an out-of-range write opens with a low-ready ERROR cycle
  a_r6_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && write && !in_range(addr)) |=> (!ready_out && resp_err));

  // R3: an in-range access opens with a wait when waits are configured
  a_r3_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_range(addr) && (WAITS > 0)) |=> (!ready_out && !resp_err));

  // R8: zero waits give an immediate in-range completion
  a_r8_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_range(addr) && (WAITS == 0)) |=> ready_out);

  // R5: a byte transfer enables exactly one lane
  a_r5_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ph_size == 2'b00) |-> $countones(lanes) == 1);

endmodule

// File: tb/bslv_top_test.sv
module bslv_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, xfer_req = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'b00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready_out, resp_err;

  logic        z_sel = 1'b0, z_req = 1'b0, z_write = 1'b0;
  logic [7:0]  z_addr = '0;
  logic [1:0]  z_size = 2'b10;
  logic [31:0] z_wdata = '0;
  logic [31:0] z_rdata;
  logic        z_ready, z_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  localparam int W = 2;

  always #2 clk = ~clk;

  bslv_top #(.WAITS(W), .DEPTH(16), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .xfer_req(xfer_req), .addr(addr),
    .write(write), .size(size), .wdata(wdata), .ready_in(ready_out),
    .rdata(rdata), .ready_out(ready_out), .resp_err(resp_err)
  );

  bslv_top #(.WAITS(0), .DEPTH(16), .ADDR_W(8)) uut_zw (
    .clk(clk), .rst_n(rst_n), .sel(z_sel), .xfer_req(z_req), .addr(z_addr),
    .write(z_write), .size(z_size), .wdata(z_wdata), .ready_in(z_ready),
    .rdata(z_rdata), .ready_out(z_ready), .resp_err(z_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      finish_run();
    end
  end

  task automatic do_xfer(input logic w, input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] d, output logic [31:0] rd,
                         output logic e, output int waits);
    @(negedge clk);
    sel = 1'b1; xfer_req = 1'b1; addr = a; write = w; size = sz;
    @(negedge clk);
    sel = 1'b0; xfer_req = 1'b0; wdata = d; waits = 0;
    while (!ready_out) begin
      waits++;
      @(negedge clk);
    end
    rd = rdata;
    e  = resp_err;
  endtask

  // {write, size, addr, wdata, expected rdata, expected err}
  localparam int NV = 15;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 2'b10, 8'h04, 32'h11223344, 32'h0,        1'b0},
    {1'b0, 2'b10, 8'h04, 32'h0,        32'h11223344, 1'b0},
    {1'b1, 2'b00, 8'h05, 32'h0000AA00, 32'h0,        1'b0},
    {1'b0, 2'b10, 8'h04, 32'h0,        32'h1122AA44, 1'b0},
    {1'b1, 2'b01, 8'h06, 32'hBEEF0000, 32'h0,        1'b0},
    {1'b0, 2'b10, 8'h04, 32'h0,        32'hBEEFAA44, 1'b0},
    {1'b1, 2'b00, 8'h07, 32'h77000000, 32'h0,        1'b0},
    {1'b0, 2'b10, 8'h04, 32'h0,        32'h77EFAA44, 1'b0},
    {1'b1, 2'b11, 8'h3C, 32'hCAFEF00D, 32'h0,        1'b0},
    {1'b0, 2'b10, 8'h3C, 32'h0,        32'hCAFEF00D, 1'b0},
    {1'b1, 2'b10, 8'h40, 32'hDEADBEEF, 32'h0,        1'b1},
    {1'b0, 2'b10, 8'h40, 32'h0,        32'h0,        1'b0},
    {1'b0, 2'b10, 8'h00, 32'h0,        32'h0,        1'b0},
    {1'b1, 2'b01, 8'h3E, 32'h12340000, 32'h0,        1'b0},
    {1'b0, 2'b10, 8'h3C, 32'h0,        32'h1234F00D, 1'b0}
  };

  initial begin
    logic [31:0] rd;
    logic        e;
    int          waits;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ready", 32'(ready_out), 32'd1);
    chk("R1 reset resp", 32'(resp_err), 32'd0);
    chk("R1 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;

    // table walk: R3 R4 R5 R6 R9 (and R1 cleared memory at 0x00)
    for (int i = 0; i < NV; i++) begin
      do_xfer(VEC[i][75], VEC[i][74:73], VEC[i][72:65], VEC[i][64:33], rd, e, waits);
      chk(VEC[i][0] ? "R6 error resp" : "R3 okay resp", 32'(e), 32'(VEC[i][0]));
      chk(VEC[i][0] ? "R6 error length" : "R3 wait count", 32'(waits),
          VEC[i][0] ? 32'd1 : 32'(W));
      if (!VEC[i][75])
        chk(VEC[i][72:65] >= 8'h40 ? "R9 out-of-range read" : "R4/R5 read data",
            rd, VEC[i][32:1]);
    end

    // R2: address shown only during stall cycles is not taken
    @(negedge clk);
    sel = 1'b1; xfer_req = 1'b1; addr = 8'h04; write = 1'b0; size = 2'b10;
    @(negedge clk);
    addr = 8'h3C; write = 1'b1; wdata = 32'hFFFFFFFF;
    chk("R2 stall 1", 32'(ready_out), 32'd0);
    @(negedge clk);
    chk("R2 stall 2", 32'(ready_out), 32'd0);
    @(negedge clk);
    chk("R2 completion", 32'(ready_out), 32'd1);
    chk("R4 read during R2", rdata, 32'h77EFAA44);
    sel = 1'b0; xfer_req = 1'b0;
    @(negedge clk);
    chk("R2 no new phase", 32'(ready_out), 32'd1);
    chk("R1 idle resp", 32'(resp_err), 32'd0);
    do_xfer(1'b0, 2'b10, 8'h3C, 32'h0, rd, e, waits);
    chk("R2 word untouched", rd, 32'h1234F00D);

    // R7: overlapping address phase, accepted at completion
    @(negedge clk);
    sel = 1'b1; xfer_req = 1'b1; addr = 8'h04; write = 1'b0;
    @(negedge clk);
    addr = 8'h3C;
    @(negedge clk);
    @(negedge clk);
    chk("R7 first done", 32'(ready_out), 32'd1);
    chk("R7 first data", rdata, 32'h77EFAA44);
    @(negedge clk);
    sel = 1'b0; xfer_req = 1'b0;
    chk("R7 second stalls at once", 32'(ready_out), 32'd0);
    @(negedge clk);
    chk("R7 second stall 2", 32'(ready_out), 32'd0);
    @(negedge clk);
    chk("R7 second done", 32'(ready_out), 32'd1);
    chk("R7 second data", rdata, 32'h1234F00D);

    // R8: zero-wait instance, write then read of the same word back to back
    @(negedge clk);
    z_sel = 1'b1; z_req = 1'b1; z_addr = 8'h08; z_write = 1'b1; z_size = 2'b10;
    @(negedge clk);
    chk("R8 write single cycle", 32'(z_ready), 32'd1);
    z_wdata = 32'h5A5AC3C3; z_write = 1'b0;
    @(negedge clk);
    z_sel = 1'b0; z_req = 1'b0;
    chk("R8 read single cycle", 32'(z_ready), 32'd1);
    chk("R8 read after write", z_rdata, 32'h5A5AC3C3);
    chk("R8 okay", 32'(z_err), 32'd0);

    finish_run();
  end

endmodule